// File: doc/BRIEF.md
# Sparse cyclic reservoir state engine

This block advances a banded, ring-connected reservoir by one time step. Each of its N nodes takes weighted contributions only from the M nodes just before it around the ring, plus a weighted scalar input and a bias. Identity activation gives x_i(t) = bias + w_in,i·u(t) + Σ w_i,j·β·x_j(t−1). All weights are powers of two with a sign. They come from a 10-bit shift-register generator that is reloaded with a fixed seed at every start, so no weight storage is needed and every multiply becomes an arithmetic shift. The spectral-radius correction β is applied once, to each old state as it leaves the state store, and not to the weights.

A single pulse on `start` runs one step. The engine reads each old state word once and broadcasts it to M chained shift-add stages. The new states stream out in node order as they are written back over the old ones, and a one-cycle `done` marks the end of the step. States persist from step to step and are cleared only by reset. Data are signed Q1.31. Every scaled value and every partial sum is clamped to [−2^31, 2^31−1]; nothing wraps.

Top module: `rsv_engine`

## Requirements
- R1: While reset is asserted, and after it is released, `done` and `state_valid` are low and every stored state is zero. A first step with u = 0 and bias = 0 therefore yields all-zero states.
- R2: `u_in` and `bias_in` are sampled at the clock edge that accepts `start`. Changes to them later in the step have no effect on the results.
- R3: `done` is high for exactly one cycle. That cycle follows the (N+M+2)-th rising edge after the accepting edge.
- R4: New states appear on `state_data` with `state_valid` high for N consecutive cycles. The stream starts in the cycle after the (M+2)-th edge following the accepting edge, with `state_idx` running 0 to N−1.
- R5: Node i (0-based) computes a0 = sat(bias + s(u, F0(L_i))). It then applies a_m = sat(a_{m−1} + s(βx_j, Fm(L_{i+m}))) for m = 1..M, with j = (i − M − 1 + m) mod N, and takes a_M as the result.
- R6: L_0 is the seed (default 0x2B5) and L_{k+1} = {L_k[8:0], L_k[9] ^ L_k[6]}, so the weights are identical in every step. Fm(L) is the 3-bit field whose bit b is L[(3m+b) mod 10]. s(x,F) is x arithmetically right-shifted by F[1:0]+1, negated when F[2] = 1.
- R7: The scaled state is βx = sat(floor(x·BETA_Q / 2^BETA_FRAC)). The defaults are BETA_Q = 9228 and BETA_FRAC = 12, so β ≈ 2.2529.
- R8: Every clamp sat() limits its result to [−2^31, 2^31−1], including when the inputs are at full scale.
- R9: A `start` pulse that arrives while a step is running is ignored. The running step's timing and results are unchanged.
- R10: A step uses the states written by the previous step. A write-back never overwrites an old state before that state has been read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins one state update when idle |
| u_in | input | 32 | Scalar input u(t), signed Q1.31 |
| bias_in | input | 32 | Bias added to every node, signed Q1.31 |
| state_valid | output | 1 | New state word present on the stream |
| state_idx | output | $clog2(N) | Node index of the streamed state |
| state_data | output | 32 | New state value, signed Q1.31 |
| done | output | 1 | One-cycle end-of-step flag |

## Verification
Write-back of node i−M−2 shares a cycle with the read of node i−M. It also shares cycles with the broadcast of the ring-wrap words, which come from a small capture store rather than from a second read. Every step with N = 8 and M = 2 provokes both overlaps. The check compares each streamed word, in its exact cycle, against an arithmetic model that holds the previous step's states, so any premature overwrite or wrong wrap source would show up as a value mismatch. A second `start` injected mid-step, together with input changes after acceptance, tests that the accept logic and the running sequence do not interfere.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  localparam int DW     = 32;
  localparam int LFSR_W = 10;
  localparam int FLD_W  = 3;

  typedef logic signed [DW-1:0] sample_t;
  typedef logic [FLD_W-1:0]     wfield_t;

  localparam logic signed [63:0] SMAX = (64'sd1 <<< (DW - 1)) - 64'sd1;
  localparam logic signed [63:0] SMIN = -(64'sd1 <<< (DW - 1));

  // clamp a wide signed value into the sample range
  function automatic sample_t sat_wide(input logic signed [63:0] v);
    logic signed [63:0] r;
    if (v > SMAX)      r = SMAX;
    else if (v < SMIN) r = SMIN;
    else               r = v;
    return r[DW-1:0];
  endfunction

  // signed power-of-two weighting: shift by f[1:0]+1, negate on f[2]
  function automatic logic signed [63:0] shift_term(input sample_t x, input wfield_t f);
    logic signed [63:0] xw;
    logic signed [63:0] t;
    xw = x;
    t  = xw >>> ({1'b0, f[1:0]} + 3'd1);
    return f[2] ? -t : t;
  endfunction
endpackage

// File: rtl/rsv_weight_gen.sv
module rsv_weight_gen
  import rsv_pkg::*;
#(
  parameter int               UNITS = 3,
  parameter logic [LFSR_W-1:0] SEED = 10'h2B5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic                          step,
  output logic [UNITS-1:0][FLD_W-1:0]   fld
);
  logic [LFSR_W-1:0] lfsr_q, lfsr_d;

  always_comb begin
    lfsr_d = lfsr_q;
    if (load)      lfsr_d = SEED;
    else if (step) lfsr_d = {lfsr_q[LFSR_W-2:0], lfsr_q[LFSR_W-1] ^ lfsr_q[6]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= SEED;
    else        lfsr_q <= lfsr_d;
  end

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    for (genvar b = 0; b < FLD_W; b++) begin : g_bit
      assign fld[u][b] = lfsr_q[(FLD_W * u + b) % LFSR_W];
    end
  end

  // R6: the generator never reaches the all-zero lock-up state
  assert_lfsr_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);
endmodule

// File: rtl/rsv_shift_unit.sv
module rsv_shift_unit
  import rsv_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    en,
  input  sample_t acc_in,
  input  sample_t mul_in,
  input  wfield_t fld,
  output sample_t acc_q
);
  sample_t acc_d;

  always_comb begin
    acc_d = acc_q;
    if (en) acc_d = sat_wide(64'(acc_in) + shift_term(mul_in, fld));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  // R8: adding a non-negative term to a non-negative sum never turns negative
  assert_no_wrap_pos_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && acc_in >= 0 && mul_in >= 0 && !fld[2]) |=> (acc_q >= 0));
  // R8: adding a non-positive term to a negative sum never turns non-negative
  assert_no_wrap_neg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && acc_in < 0 && mul_in >= 0 && fld[2]) |=> (acc_q < 0));
endmodule

// File: rtl/rsv_state_mem.sv
module rsv_state_mem
  import rsv_pkg::*;
#(
  parameter int N   = 100,
  parameter int M   = 5,
  parameter int AW  = 7,
  parameter int CIW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rd_en,
  input  logic [AW-1:0]  raddr,
  input  logic           wr_en,
  input  logic [AW-1:0]  waddr,
  input  sample_t        wdata,
  input  logic           cap_en,
  input  logic [CIW-1:0] cap_idx,
  input  logic           use_cache,
  input  logic [CIW-1:0] cache_idx,
  output sample_t        bcast
);
  localparam int CN = (M > 1) ? M - 1 : 1;

  sample_t mem_q [N];
  sample_t cache_q [CN];
  sample_t rdata_q, rdata_d;

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) rdata_d = mem_q[raddr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      for (int i = 0; i < N; i++) mem_q[i] <= '0;
    end else begin
      rdata_q <= rdata_d;
      if (wr_en) mem_q[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CN; i++) cache_q[i] <= '0;
    end else if (cap_en) begin
      cache_q[cap_idx] <= rdata_q;
    end
  end

  assign bcast = use_cache ? cache_q[cache_idx] : rdata_q;

  // R10: a write-back never targets the word being read in the same cycle
  assert_no_clash_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en) |-> (raddr != waddr));
endmodule

// File: rtl/rsv_ctrl.sv
module rsv_ctrl #(
  parameter int N   = 100,
  parameter int M   = 5,
  parameter int AW  = 7,
  parameter int CIW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  output logic           busy,
  output logic           accept,
  output logic           done,
  output logic           rd_en,
  output logic [AW-1:0]  raddr,
  output logic           wr_en,
  output logic [AW-1:0]  waddr,
  output logic           cap_en,
  output logic [CIW-1:0] cap_idx,
  output logic           use_cache,
  output logic [CIW-1:0] cache_idx
);
  localparam int          CYW   = $clog2(N + M + 3);
  localparam logic [31:0] NU    = 32'(N);
  localparam logic [31:0] MU    = 32'(M);
  localparam logic [31:0] LASTU = 32'(N + M + 1);

  logic           busy_q, busy_d;
  logic           done_q, done_d;
  logic [CYW-1:0] cyc_q, cyc_d;
  logic [31:0]    cnum;

  assign cnum   = 32'(cyc_q);
  assign accept = !busy_q && start;

  always_comb begin
    busy_d = busy_q;
    cyc_d  = cyc_q;
    done_d = 1'b0;
    if (accept) begin
      busy_d = 1'b1;
      cyc_d  = '0;
    end else if (busy_q) begin
      if (cnum == LASTU) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        cyc_d = cyc_q + CYW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cyc_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cyc_q  <= cyc_d;
    end
  end

  // address and strobe decode from the step counter
  always_comb begin
    rd_en     = busy_q && (cnum < NU);
    raddr     = (cnum >= MU) ? AW'(cnum - MU) : AW'(cnum + NU - MU);
    wr_en     = busy_q && (cnum >= MU + 32'd2);
    waddr     = AW'(cnum - MU - 32'd2);
    cap_en    = busy_q && (cnum >= 32'd1) && (cnum <= MU - 32'd1);
    cap_idx   = CIW'(cnum - 32'd1);
    use_cache = busy_q && (cnum >= NU + 32'd1);
    cache_idx = CIW'(cnum - 32'd1 - NU);
  end

  assign busy = busy_q;
  assign done = done_q;

  // R3: done is a single-cycle pulse
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R9: a running step is not cut short or restarted
  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnum != LASTU) |=> (busy_q && cyc_q == $past(cyc_q) + CYW'(1)));
endmodule

// File: rtl/rsv_engine.sv
module rsv_engine
  import rsv_pkg::*;
#(
  parameter int                N         = 100,
  parameter int                M         = 5,
  parameter logic [LFSR_W-1:0] SEED      = 10'h2B5,
  parameter int                BETA_Q    = 9228,
  parameter int                BETA_FRAC = 12,
  localparam int               AW        = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic signed [31:0]   u_in,
  input  logic signed [31:0]   bias_in,
  output logic                 state_valid,
  output logic [AW-1:0]        state_idx,
  output logic signed [31:0]   state_data,
  output logic                 done
);
  localparam int CN  = (M > 1) ? M - 1 : 1;
  localparam int CIW = (CN > 1) ? $clog2(CN) : 1;

  logic           busy, accept, rd_en, wr_en, cap_en, use_cache;
  logic [AW-1:0]  raddr, waddr;
  logic [CIW-1:0] cap_idx, cache_idx;
  logic [M:0][FLD_W-1:0] fld;

  sample_t u_q, u_d, bias_q, bias_d;
  sample_t act_q, act_d;
  sample_t bcast, scaled;
  sample_t chain [M+1];

  rsv_ctrl #(.N(N), .M(M), .AW(AW), .CIW(CIW)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .accept(accept),
    .done(done), .rd_en(rd_en), .raddr(raddr), .wr_en(wr_en), .waddr(waddr),
    .cap_en(cap_en), .cap_idx(cap_idx), .use_cache(use_cache),
    .cache_idx(cache_idx)
  );

  rsv_weight_gen #(.UNITS(M + 1), .SEED(SEED)) wgen_i (
    .clk(clk), .rst_n(rst_n), .load(accept), .step(busy), .fld(fld)
  );

  rsv_state_mem #(.N(N), .M(M), .AW(AW), .CIW(CIW)) mem_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .raddr(raddr), .wr_en(wr_en),
    .waddr(waddr), .wdata(act_q), .cap_en(cap_en), .cap_idx(cap_idx),
    .use_cache(use_cache), .cache_idx(cache_idx), .bcast(bcast)
  );

  // operand capture at the accepting edge
  always_comb begin
    u_d    = u_q;
    bias_d = bias_q;
    if (accept) begin
      u_d    = u_in;
      bias_d = bias_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      u_q    <= '0;
      bias_q <= '0;
    end else begin
      u_q    <= u_d;
      bias_q <= bias_d;
    end
  end

  // spectral-radius correction on the broadcast state word
  always_comb begin
    logic signed [63:0] xw, bw, pr;
    xw     = bcast;
    bw     = 64'(BETA_Q);
    pr     = (xw * bw) >>> BETA_FRAC;
    scaled = sat_wide(pr);
  end

  // input unit followed by the state-weighting chain
  rsv_shift_unit unit_in_i (
    .clk(clk), .rst_n(rst_n), .en(busy), .acc_in(bias_q), .mul_in(u_q),
    .fld(fld[0]), .acc_q(chain[0])
  );

  for (genvar m = 1; m <= M; m++) begin : g_chain
    rsv_shift_unit unit_i (
      .clk(clk), .rst_n(rst_n), .en(busy), .acc_in(chain[m-1]), .mul_in(scaled),
      .fld(fld[m]), .acc_q(chain[m])
    );
  end

  // identity activation: one register stage
  always_comb begin
    act_d = act_q;
    if (busy) act_d = chain[M];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= act_d;
  end

  assign state_valid = wr_en;
  assign state_idx   = waddr;
  assign state_data  = act_q;

  // R4: done follows directly on the write of the last node
  assert_done_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(state_valid) && $past(state_idx) == AW'(N - 1)));
  // R7: a clamped scaled value keeps the sign of the stored state
  assert_scale_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bcast < 0) |-> (scaled <= 0));
endmodule

// File: tb/rsv_engine_tb_top.sv
module rsv_engine_tb_top;
  localparam int N  = 8;
  localparam int M  = 2;
  localparam logic [9:0] SEED = 10'h2B5;
  localparam int BQ = 9228;
  localparam int BF = 12;
  localparam longint SMAXL = 64'sd2147483647;
  localparam longint SMINL = -64'sd2147483648;

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic signed [31:0] u_in, bias_in;
  logic state_valid, done;
  logic [2:0] state_idx;
  logic signed [31:0] state_data;

  int errors = 0;
  int checks = 0;
  longint model_x [N];

  always #10 clk = ~clk;

  rsv_engine #(.N(N), .M(M), .SEED(SEED), .BETA_Q(BQ), .BETA_FRAC(BF)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .u_in(u_in), .bias_in(bias_in),
    .state_valid(state_valid), .state_idx(state_idx), .state_data(state_data),
    .done(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sat(input longint v);
    if (v > SMAXL) return SMAXL;
    if (v < SMINL) return SMINL;
    return v;
  endfunction

  function automatic int fld(input int l, input int m);
    int r = 0;
    for (int b = 0; b < 3; b++) r |= ((l >> ((3 * m + b) % 10)) & 1) << b;
    return r;
  endfunction

  function automatic longint shw(input longint x, input int f);
    longint t = x >>> ((f & 3) + 1);
    return ((f & 4) != 0) ? -t : t;
  endfunction

  function automatic int lstep(input int l);
    return ((l << 1) & 10'h3FF) | (((l >> 9) ^ (l >> 6)) & 1);
  endfunction

  task automatic run_step(input longint u, input longint b, input bit poke, input string tag);
    int     ls [N + M + 1];
    longint xs [N];
    longint nx [N];
    longint acc;
    ls[0] = int'(SEED);
    for (int k = 1; k <= N + M; k++) ls[k] = lstep(ls[k-1]);
    for (int j = 0; j < N; j++) xs[j] = sat((model_x[j] * BQ) >>> BF);
    for (int i = 0; i < N; i++) begin
      acc = sat(b + shw(u, fld(ls[i], 0)));
      for (int m = 1; m <= M; m++)
        acc = sat(acc + shw(xs[(i - M - 1 + m + N) % N], fld(ls[i + m], m)));
      nx[i] = acc;
    end
    @(negedge clk);
    start = 1'b1; u_in = 32'(u); bias_in = 32'(b);
    @(negedge clk);
    start = 1'b0; u_in = 32'sh5A5A5A5A; bias_in = 32'sh7FFF0000;  // R2 later changes ignored
    for (int c = 0; c <= N + M + 3; c++) begin
      if (c > 0) @(negedge clk);
      if (poke && c == 4) begin start = 1'b1; u_in = 32'sh3C3C3C3C; end  // R9
      if (poke && c == 5) start = 1'b0;
      chk(state_valid == (c >= M + 2 && c <= N + M + 1), {"R4 valid ", tag},
          longint'(state_valid), longint'(c >= M + 2 && c <= N + M + 1));
      chk(done == (c == N + M + 2), {"R3 done ", tag}, longint'(done),
          longint'(c == N + M + 2));
      if (c >= M + 2 && c <= N + M + 1) begin
        chk(state_idx == 3'(c - M - 2), {"R4 idx ", tag}, longint'(state_idx),
            longint'(c - M - 2));
        chk(longint'(state_data) == nx[c - M - 2], {"R5 R6 R7 R10 data ", tag},
            longint'(state_data), nx[c - M - 2]);
      end
    end
    for (int i = 0; i < N; i++) model_x[i] = nx[i];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; u_in = '0; bias_in = '0;
    for (int i = 0; i < N; i++) model_x[i] = 0;
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1 done in reset", longint'(done), 0);
    chk(state_valid == 1'b0, "R1 valid in reset", longint'(state_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0 && state_valid == 1'b0, "R1 idle after reset",
        longint'({done, state_valid}), 0);
    run_step(0, 0, 1'b0, "R1 zero");
    run_step(64'sh40000000, 64'sh08000000, 1'b0, "R2 basic");
    run_step(-64'sh26666666, 64'sh19999999, 1'b1, "R9 poke");
    run_step(64'sh7FFFFFFF, 64'sh7FFFFFFF, 1'b0, "R8 sat high");
    run_step(-64'sh80000000, -64'sh80000000, 1'b0, "R8 sat low");
    run_step(64'sh10000000, -64'sh05000000, 1'b1, "R10 chain");
    run_step(64'sh33333333, 0, 1'b0, "R7 beta");
    run_step(-64'sh12345678, 64'sh01000000, 1'b0, "R6 repeat");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule